// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level and absorbs the stream of stores from the processor. It keeps a small set of block-sized entries. Each entry has a block address, a byte-valid mask and one data word for each word position in the block. An incoming store is compared against every buffered block. If an unlocked entry holds the same block, the store's enabled bytes are written into that entry. If not, the store takes a free entry. The processor is held off only when every entry is in use and the store cannot be merged.

Entries leave for memory in the background, oldest first, one burst at a time. A burst carries the block-aligned address, all data words, a word mask and a byte mask. It is held steady on a request/acknowledge port until memory accepts it. The entry on the port is locked. A later store to the same block then opens a fresh entry instead of changing data that is already in flight.

The drain sequencer has two states. In DR_IDLE it waits. It moves DR_IDLE to DR_SEND when at least one entry is pending. It stays in DR_SEND while mem_ack is low, holding the oldest entry on the port. It moves DR_SEND to DR_IDLE on mem_ack, which frees that entry.

Top module: `wbm_merge_buf`

## Requirements
- R1: After reset, st_stall and mem_req are low, even with a store presented.
- R2: A store whose block address equals that of a valid, unlocked entry merges into that entry. No new entry is taken, so both stores leave in one burst.
- R3: A store that matches no unlocked entry is accepted into a free entry without stalling, as long as fewer than 4 entries are in use.
- R4: With all 4 entries in use and no unlocked match, st_stall is high. The store is taken in the cycle after an entry has drained.
- R5: A store that can merge never stalls, even when all entries are in use.
- R6: Entries drain in allocation order, oldest first. mem_req is high only while at least one entry is buffered, and every entry eventually drains.
- R7: The entry being drained (mem_req high) is locked. A store to its block takes a new entry and leaves in a later burst.
- R8: A store writes only the bytes enabled by st_be (bit b covers data bits 8b+7..8b) of word st_addr[3:2]. A newer write to a byte replaces the older one. mem_bmask bit 4w+b is set when byte b of word w has been written.
- R9: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_data and mem_bmask stay unchanged into the next cycle.
- R10: A burst presents the block address with bits 3:0 zero, word w on mem_data bits 32w+31..32w, and mem_wmask bit w set exactly when any byte of word w was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store present; held while stalled |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| mem_req | output | 1 | Burst request to memory |
| mem_addr | output | 32 | Block-aligned burst address |
| mem_data | output | 128 | All words of the block |
| mem_wmask | output | 4 | Words holding written bytes |
| mem_bmask | output | 16 | Bytes written |
| mem_ack | input | 1 | Memory accepts the burst |

## Verification
The hardest case to reach from the ports is a store to the block that is on the memory port while the other entries are full. Here the locked entry must not merge, and the store either stalls or opens a new entry, depending on the fill level in that exact cycle. The directed part holds mem_ack low, so the first block locks one cycle after it is allocated. It then stores to that block again, fills the rest, and mixes stalled and merging stores. A random phase then draws stores from only five blocks and acknowledges rarely, so that the buffer is full most of the time and drains often land in the same cycle as a store.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    typedef enum logic {
        DR_IDLE,
        DR_SEND
    } drain_state_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbm_tag_match.sv
module wbm_tag_match #(
    parameter int N  = 4,
    parameter int TW = 28,
    localparam int IW = wbm_pkg::idx_bits(N)
) (
    input  logic [N-1:0]    ent_valid,
    input  logic [N*TW-1:0] ent_tags,
    input  logic [TW-1:0]   probe_tag,
    input  logic            lock_on,
    input  logic [IW-1:0]   lock_idx,
    output logic [N-1:0]    match_vec,
    output logic            hit,
    output logic [IW-1:0]   hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g]
                            && (ent_tags[g*TW +: TW] == probe_tag)
                            && !(lock_on && (lock_idx == IW'(g)));
    end

    assign hit = |match_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/wbm_age_fifo.sv
module wbm_age_fifo #(
    parameter int N = 4,
    localparam int IW = wbm_pkg::idx_bits(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic [CW-1:0] count,
    output logic          nonempty
);

    logic [IW-1:0] q [N];
    logic [IW-1:0] rd_ptr, wr_ptr;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < N; i++) q[i] <= '0;
        end else begin
            if (push) begin
                q[wr_ptr] <= push_idx;
                wr_ptr    <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_idx = q[rd_ptr];
    assign nonempty = (count != '0);

endmodule

// File: rtl/wbm_drain_fsm.sv
module wbm_drain_fsm
    import wbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic mem_ack,
    output logic mem_req,
    output logic lock,
    output logic retire
);

    drain_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE: if (pending) state_nx = DR_SEND;
            DR_SEND: if (mem_ack) state_nx = DR_IDLE;
            default: state_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        lock    = 1'b0;
        retire  = 1'b0;
        unique case (state)
            DR_IDLE: ;
            DR_SEND: begin
                mem_req = 1'b1;
                lock    = 1'b1;
                retire  = mem_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wbm_merge_buf.sv
module wbm_merge_buf #(
    parameter int N     = 4,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int AW    = 32,
    localparam int BPW  = DW / 8,
    localparam int BPB  = WORDS * BPW,
    localparam int BYB  = $clog2(BPW),
    localparam int OFFB = $clog2(BPB),
    localparam int WIB  = OFFB - BYB,
    localparam int TW   = AW - OFFB,
    localparam int IW   = wbm_pkg::idx_bits(N),
    localparam int CW   = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic [AW-1:0]       st_addr,
    input  logic [DW-1:0]       st_data,
    input  logic [BPW-1:0]      st_be,
    output logic                st_stall,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    output logic [WORDS*DW-1:0] mem_data,
    output logic [WORDS-1:0]    mem_wmask,
    output logic [BPB-1:0]      mem_bmask,
    input  logic                mem_ack
);

    logic [N-1:0]    valid_q;
    logic [TW-1:0]   tag_q  [N];
    logic [DW-1:0]   data_q [N][WORDS];
    logic [BPB-1:0]  bm_q   [N];

    logic [N*TW-1:0] tags_flat;
    logic [TW-1:0]   st_tag;
    logic [WIB-1:0]  st_widx;
    logic [BPB-1:0]  new_bm;
    logic [N-1:0]    match_vec;
    logic            hit, free_any, accept, lock, retire, pending;
    logic [IW-1:0]   hit_idx, free_idx, tgt, head_idx;
    logic [CW-1:0]   fill_count;

    assign st_tag  = st_addr[AW-1:OFFB];
    assign st_widx = st_addr[OFFB-1:BYB];

    always_comb begin
        for (int i = 0; i < N; i++) tags_flat[i*TW +: TW] = tag_q[i];
    end

    wbm_tag_match #(.N(N), .TW(TW)) u_match (
        .ent_valid (valid_q),
        .ent_tags  (tags_flat),
        .probe_tag (st_tag),
        .lock_on   (lock),
        .lock_idx  (head_idx),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    assign st_stall = st_valid && !hit && !free_any;
    assign accept   = st_valid && !st_stall;
    assign tgt      = hit ? hit_idx : free_idx;

    always_comb begin
        new_bm = '0;
        new_bm[st_widx*BPW +: BPW] = st_be;
    end

    wbm_age_fifo #(.N(N)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept && !hit),
        .push_idx (free_idx),
        .pop      (retire),
        .head_idx (head_idx),
        .count    (fill_count),
        .nonempty (pending)
    );

    wbm_drain_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .mem_ack (mem_ack),
        .mem_req (mem_req),
        .lock    (lock),
        .retire  (retire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i] <= '0;
                bm_q[i]  <= '0;
                for (int w = 0; w < WORDS; w++) data_q[i][w] <= '0;
            end
        end else begin
            if (retire) valid_q[head_idx] <= 1'b0;
            if (accept) begin
                if (!hit) begin
                    valid_q[tgt] <= 1'b1;
                    tag_q[tgt]   <= st_tag;
                    bm_q[tgt]    <= new_bm;
                end else begin
                    bm_q[tgt]    <= bm_q[tgt] | new_bm;
                end
                for (int b = 0; b < BPW; b++) begin
                    if (st_be[b]) data_q[tgt][st_widx][8*b +: 8] <= st_data[8*b +: 8];
                end
            end
        end
    end

    always_comb begin
        mem_addr  = {tag_q[head_idx], {OFFB{1'b0}}};
        mem_bmask = bm_q[head_idx];
        for (int w = 0; w < WORDS; w++) begin
            mem_data[w*DW +: DW] = data_q[head_idx][w];
            mem_wmask[w]         = |bm_q[head_idx][w*BPW +: BPW];
        end
    end

endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
    parameter int N   = 4,
    parameter int AW  = 32,
    parameter int MDW = 128,
    parameter int BPB = 16,
    parameter int CW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           st_valid,
    input logic           st_stall,
    input logic           mem_req,
    input logic           mem_ack,
    input logic [AW-1:0]  mem_addr,
    input logic [MDW-1:0] mem_data,
    input logic [BPB-1:0] mem_bmask,
    input logic           hit,
    input logic [N-1:0]   match_vec,
    input logic [CW-1:0]  fill_count
);

    assert_stall_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (fill_count == CW'(N)));

    assert_merge_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && hit) |-> !st_stall);

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_bmask)));

    assert_req_has_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (fill_count != '0));

endmodule

bind wbm_merge_buf wbm_checker #(
    .N(N), .AW(AW), .MDW(WORDS*DW), .BPB(BPB), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_stall   (st_stall),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_bmask  (mem_bmask),
    .hit        (hit),
    .match_vec  (match_vec),
    .fill_count (fill_count)
);

// File: tb/test_wbm_merge_buf.sv
module test_wbm_merge_buf;

    localparam int N = 4;
    localparam int TAGW = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         st_stall, mem_req, mem_ack = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_wmask;
    logic [15:0]  mem_bmask;

    wbm_merge_buf i_wbm_merge_buf (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_wmask(mem_wmask), .mem_bmask(mem_bmask), .mem_ack(mem_ack)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, bursts = 0;

    // reference model: list of entries, index 0 = oldest
    int            m_n = 0;
    logic [TAGW-1:0] m_tag [N];
    logic [31:0]   m_dat [N][4];
    logic [15:0]   m_bm  [N];

    bit            p_hold = 1'b0;
    logic [31:0]   p_addr;
    logic [127:0]  p_data;
    logic [15:0]   p_bm;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [127:0] head_data_exp();
        logic [127:0] r;
        for (int w = 0; w < 4; w++) r[32*w +: 32] = m_dat[0][w];
        return r;
    endfunction

    function automatic logic [127:0] byte_expand(input logic [15:0] bm);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[8*b +: 8] = {8{bm[b]}};
        return r;
    endfunction

    function automatic logic [3:0] wmask_of(input logic [15:0] bm);
        logic [3:0] r;
        for (int w = 0; w < 4; w++) r[w] = |bm[4*w +: 4];
        return r;
    endfunction

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit ack, output bit acc);
        bit lock, exp_stall;
        int mi;
        logic [1:0] wi;
        logic [127:0] msk;
        @(negedge clk);
        st_valid = v; st_addr = a; st_data = d; st_be = be; mem_ack = ack;
        #1;
        lock = mem_req;
        if (p_hold)
            chk(mem_req && mem_addr == p_addr && mem_data == p_data && mem_bmask == p_bm,
                "R9 port held", {mem_req, mem_addr}, {1'b1, p_addr});
        if (mem_req) begin
            chk(m_n > 0, "R6 request without entry", 128'(m_n), 128'd1);
            if (m_n > 0 && ack) begin
                chk(mem_addr == {m_tag[0], 4'b0}, "R6 R10 burst address order",
                    128'(mem_addr), 128'({m_tag[0], 4'b0}));
                chk(mem_wmask == wmask_of(m_bm[0]), "R2 R10 word mask",
                    128'(mem_wmask), 128'(wmask_of(m_bm[0])));
                chk(mem_bmask == m_bm[0], "R8 byte mask", 128'(mem_bmask), 128'(m_bm[0]));
                msk = byte_expand(m_bm[0]);
                chk((mem_data & msk) == (head_data_exp() & msk), "R8 R10 burst data",
                    mem_data & msk, head_data_exp() & msk);
            end
        end
        mi = -1;
        for (int i = 0; i < m_n; i++)
            if (!(lock && i == 0) && m_tag[i] == a[31:4] && mi < 0) mi = i;
        exp_stall = v && (mi < 0) && (m_n == N);
        if (v) begin
            if (mi >= 0 && m_n == N)
                chk(st_stall == 1'b0, "R5 merge while full", 128'(st_stall), 128'd0);
            else if (exp_stall)
                chk(st_stall == 1'b1, "R4 stall when full", 128'(st_stall), 128'd1);
            else
                chk(st_stall == 1'b0, "R3 R7 accept store", 128'(st_stall), 128'd0);
        end
        acc = v && !exp_stall;
        if (acc) begin
            if (mi < 0) begin
                mi = m_n;
                m_n++;
                m_tag[mi] = a[31:4];
                m_bm[mi] = '0;
            end
            wi = a[3:2];
            for (int b = 0; b < 4; b++)
                if (be[b]) begin
                    m_dat[mi][wi][8*b +: 8] = d[8*b +: 8];
                    m_bm[mi][4*wi + b] = 1'b1;
                end
        end
        if (mem_req && ack && m_n > 0) begin
            for (int i = 0; i < N - 1; i++) begin
                m_tag[i] = m_tag[i+1];
                m_bm[i] = m_bm[i+1];
                for (int w = 0; w < 4; w++) m_dat[i][w] = m_dat[i+1][w];
            end
            m_n--;
            bursts++;
        end
        p_hold = mem_req && !ack;
        p_addr = mem_addr; p_data = mem_data; p_bm = mem_bmask;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input bit ack);
        bit acc;
        for (int t = 0; t < 100; t++) begin
            step(1'b1, a, d, be, ack, acc);
            if (acc) break;
        end
    endtask

    initial begin
        bit acc, pend;
        logic [31:0] pa, pd;
        logic [3:0] pbe;
        void'($urandom(32'd20240611));

        // R1: reset state, store presented during reset
        st_valid = 1'b1; st_addr = 32'h100; st_be = 4'hF;
        repeat (3) @(negedge clk);
        chk(st_stall == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
            {st_stall, mem_req}, 2'b00);
        st_valid = 1'b0;
        rst_n = 1'b1;

        // R2 merge before lock, R7 store after lock opens new entry
        put(32'h0000_1000, 32'h1111_1111, 4'hF, 1'b0);
        put(32'h0000_1004, 32'h2222_2222, 4'hF, 1'b0);
        put(32'h0000_1008, 32'h3333_3333, 4'hF, 1'b0);
        put(32'h0000_2000, 32'h4444_4444, 4'hF, 1'b0);
        // R8 byte enables and overwrite
        put(32'h0000_3008, 32'hAAAA_AAAA, 4'b0011, 1'b0);
        put(32'h0000_3008, 32'hBBBB_BBBB, 4'b1100, 1'b0);
        put(32'h0000_3008, 32'hCCCC_CCCC, 4'b0100, 1'b0);
        // full now: R4 stall for a new block
        for (int k = 0; k < 3; k++) step(1'b1, 32'h0000_4000, 32'h5555_5555, 4'hF, 1'b0, acc);
        // R5 merge while full
        step(1'b1, 32'h0000_200C, 32'h6666_6666, 4'hF, 1'b0, acc);
        // R4 store taken after a drain
        put(32'h0000_4000, 32'h5555_5555, 4'hF, 1'b1);
        for (int k = 0; k < 20; k++) step(1'b0, '0, '0, '0, 1'b1, acc);
        chk(m_n == 0 && bursts == 5, "R6 R7 directed bursts", 128'(bursts), 128'd5);

        // random phase
        pend = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (!pend && ($urandom % 4) != 0) begin
                pend = 1'b1;
                pa = {20'h0, 4'($urandom % 5), 2'b0, 2'($urandom), 2'b0};
                pd = $urandom;
                pbe = 4'($urandom);
                if (pbe == 4'h0) pbe = 4'h1;
            end
            step(pend, pa, pd, pbe, ($urandom % 4) == 0, acc);
            if (acc) pend = 1'b0;
        end

        for (int k = 0; k < 40; k++) step(1'b0, '0, '0, '0, 1'b1, acc);
        #1;
        chk(m_n == 0 && mem_req == 1'b0, "R6 all drained", 128'(m_n), 128'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule